// File: doc/BRIEF.md
# Burst-Read, Byte-Write Bus Traffic Master

This block is a self-running AHB-Lite bus master with no software-visible control. After reset it stays idle for a set number of cycles. It then fetches four doublewords from a fixed source region with one incrementing burst and keeps them in an internal bank. After a second idle gap it drains the 32 stored bytes, one byte per transfer, to a single fixed destination address. The byte with the lowest significance goes first. This read-then-drain loop repeats until reset, and each pass uses the same two addresses. The block is meant as a deterministic source of traffic that can stand next to real masters on a shared bus.

Data moves in both directions through the bus itself. HREADY is the back-pressure signal. While a data phase is stalled, the pending address phase is frozen: address, transfer type, direction, size and burst stay as they are. None of the block's counters move until the slave accepts the transfer. The slave answers each read beat with a two-bit response. Any value other than OKAY makes the master drop that beat, and the matching bank entry keeps its previous contents.

Top module: `ahb_burst_byte_master`

## Requirements
- R1: While HRESETn is low, HTRANS is IDLE (2'b00), HMASTLOCK is low and HWDATA is all zero. All bank entries return to zero.
- R2: HTRANS stays IDLE for exactly IDLE_GAP cycles (at least one) before the first address phase of each phase. The gap is counted from the first cycle after reset release, or from the cycle after the final data phase of the previous phase completes.
- R3: A read phase is four address phases at SRC_ADDR + 8*k (k = 0..3). The first uses NONSEQ (2'b10) and the others use SEQ (2'b11). All of them use HBURST INCR4 (3'b011), HSIZE doubleword (3'b011) and HWRITE low.
- R4: A write phase is 32 address phases. Each one uses NONSEQ, HADDR equal to DST_ADDR, HBURST SINGLE (3'b000), HSIZE byte (3'b000) and HWRITE high.
- R5: HMASTLOCK is high with every write address phase and low with every read address phase.
- R6: Write k (k = 0..31) carries bit-byte k mod 8 of bank entry k/8. Entry j holds the beat read from SRC_ADDR + 8*j, and byte n of an entry is its bits 8n+7:8n.
- R7: During a write data phase, the byte sits on lane DST_ADDR[2:0], that is bits 8*lane+7:8*lane of HWDATA. Every other HWDATA bit is zero.
- R8: While HREADY is low with a non-IDLE address phase pending, HADDR, HTRANS, HWRITE, HSIZE and HBURST hold their values into the next cycle.
- R9: A read data phase that completes with HRESP other than 2'b00 leaves its bank entry unchanged. The old value then shows up in the following write phase.
- R10: The read/write loop repeats without end, with identical addresses and control on every pass.
- R11: With ENABLE set to 0, HTRANS is IDLE in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| haddr | output | 32 | Address of the current address phase |
| htrans | output | 2 | Transfer type (IDLE, NONSEQ, SEQ) |
| hwrite | output | 1 | High for write transfers |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hmastlock | output | 1 | Locked-transfer indication |
| hwdata | output | 64 | Write data, valid in write data phases |
| hrdata | input | 64 | Read data from the slave |
| hready | input | 1 | Transfer done / stall from the slave |
| hresp | input | 2 | Transfer response from the slave |

## Verification
The bench uses a slave model and runs the block under three slave patterns in turn. The first pass answers every beat at once. This isolates the idle-gap timing, the address and control sequences, and byte steering with no stalls. The second pass inserts wait states on a fixed cadence and returns an error on the third read beat. That error separates correct discard of the beat from a bank that records every beat, and the wait states show whether the address phase and counters freeze under stall. The third pass keeps the stalls but sends no error, which shows that a clean burst refreshes the whole bank. A second instance with ENABLE at 0 is watched for any non-IDLE transfer.

// File: rtl/ahb_bm_pkg.sv
package ahb_bm_pkg;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR4  = 3'b011;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;
  localparam logic [1:0] RESP_RETRY = 2'b10;
  localparam logic [1:0] RESP_SPLIT = 2'b11;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_WAIT_RD,
    PH_READ,
    PH_WAIT_WR,
    PH_WRITE
  } phase_e;

  // Every code other than OKAY counts as a failed beat.
  function automatic logic resp_is_okay(input logic [1:0] resp);
    logic ok;
    case (resp)
      RESP_OKAY:  ok = 1'b1;
      RESP_ERROR: ok = 1'b0;
      RESP_RETRY: ok = 1'b0;
      RESP_SPLIT: ok = 1'b0;
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ahb_bm_gap_timer.sv
module ahb_bm_gap_timer #(
  parameter int CNT_W = 10,
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam logic [CNT_W:0] LIMIT_V = (CNT_W+1)'(LIMIT);

  logic [CNT_W:0] cnt_q;
  logic [CNT_W:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  // A limit of zero still gives one idle cycle.
  assign done    = run && (cnt_inc >= LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc;
    end
  end

endmodule

// File: rtl/ahb_bm_sequencer.sv
module ahb_bm_sequencer
  import ahb_bm_pkg::*;
#(
  parameter bit ENABLE      = 1'b1,
  parameter int BEATS       = 4,
  parameter int TOTAL_BYTES = 32,
  parameter int CNT_W       = 6,
  parameter int IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hready,
  input  logic             wait_done,
  output phase_e           phase,
  output logic [CNT_W-1:0] addr_cnt,
  output logic             issuing,
  output logic             wait_run,
  output logic             dph_valid,
  output logic             dph_rd,
  output logic [IDX_W-1:0] dph_idx
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(BEATS);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(TOTAL_BYTES);

  phase_e           phase_d;
  logic             busy;
  logic             phase_end;
  logic [CNT_W-1:0] last_cnt;

  assign busy      = (phase == PH_READ) || (phase == PH_WRITE);
  assign last_cnt  = (phase == PH_READ) ? RD_LAST : WR_LAST;
  assign issuing   = busy && (addr_cnt < last_cnt);
  assign phase_end = busy && (addr_cnt == last_cnt) && dph_valid && hready;
  assign wait_run  = (phase == PH_WAIT_RD) || (phase == PH_WAIT_WR);

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_WAIT_RD: if (wait_done) phase_d = PH_READ;
      PH_READ:    if (phase_end) phase_d = PH_WAIT_WR;
      PH_WAIT_WR: if (wait_done) phase_d = PH_WRITE;
      PH_WRITE:   if (phase_end) phase_d = PH_WAIT_RD;
      default:    phase_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if (ENABLE) phase <= PH_WAIT_RD;
      else        phase <= PH_OFF;
      addr_cnt  <= '0;
      dph_valid <= 1'b0;
      dph_rd    <= 1'b0;
      dph_idx   <= '0;
    end else begin
      phase <= phase_d;
      if (!busy || (phase_d != phase)) begin
        addr_cnt <= '0;
      end else if (issuing && hready) begin
        addr_cnt <= addr_cnt + 1'b1;
      end
      // The address phase moves into the data phase only when the slave is ready.
      if (hready) begin
        dph_valid <= issuing;
        dph_rd    <= (phase == PH_READ);
        dph_idx   <= addr_cnt[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ahb_bm_bank.sv
module ahb_bm_bank #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 64,
  parameter int ENT_W   = 2,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_byte_idx,
  output logic [7:0]        rd_byte
);

  localparam int LANE_W = IDX_W - ENT_W;

  logic [DATA_W-1:0] ent_q [ENTRIES];
  logic [DATA_W-1:0] sel_ent;
  logic [ENT_W-1:0]  rd_ent;
  logic [LANE_W-1:0] rd_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_ent  = rd_byte_idx[IDX_W-1:LANE_W];
  assign rd_lane = rd_byte_idx[LANE_W-1:0];
  assign sel_ent = ent_q[rd_ent];
  assign rd_byte = sel_ent[{rd_lane, 3'b000} +: 8];

endmodule

// File: rtl/ahb_bm_lane_steer.sv
module ahb_bm_lane_steer #(
  parameter int DATA_W = 64,
  parameter int LANE   = 0
) (
  input  logic              en,
  input  logic [7:0]        byte_in,
  output logic [DATA_W-1:0] data_out
);

  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == LANE) begin : g_hit
      assign data_out[8*g +: 8] = en ? byte_in : 8'h00;
    end else begin : g_zero
      assign data_out[8*g +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/ahb_burst_byte_master.sv
module ahb_burst_byte_master
  import ahb_bm_pkg::*;
#(
  parameter bit          ENABLE   = 1'b1,
  parameter logic [7:0]  SRC_TOP  = 8'h20,
  parameter logic [23:0] SRC_LOW  = 24'h000000,
  parameter logic [7:0]  DST_TOP  = 8'h40,
  parameter logic [23:0] DST_LOW  = 24'h000000,
  parameter logic [9:0]  IDLE_GAP = 10'd16,
  parameter int          DATA_W   = 64,
  parameter int          BEATS    = 4
) (
  input  logic              hclk,
  input  logic              hresetn,
  output logic [31:0]       haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic              hmastlock,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic [1:0]        hresp
);

  localparam logic [31:0] SRC_ADDR    = {SRC_TOP, SRC_LOW};
  localparam logic [31:0] DST_ADDR    = {DST_TOP, DST_LOW};
  localparam int          BEAT_BYTES  = DATA_W / 8;
  localparam int          LANE_W      = $clog2(BEAT_BYTES);
  localparam int          TOTAL_BYTES = BEATS * BEAT_BYTES;
  localparam int          CNT_W       = $clog2(TOTAL_BYTES + 1);
  localparam int          IDX_W       = $clog2(TOTAL_BYTES);
  localparam int          ENT_W       = $clog2(BEATS);
  localparam int          DST_LANE    = int'(DST_ADDR[LANE_W-1:0]);
  localparam logic [2:0]  SIZE_BEAT   = 3'(LANE_W);
  localparam logic [2:0]  SIZE_BYTE   = 3'b000;

  phase_e           phase;
  logic [CNT_W-1:0] addr_cnt;
  logic             issuing;
  logic             wait_run;
  logic             wait_done;
  logic             dph_valid;
  logic             dph_rd;
  logic [IDX_W-1:0] dph_idx;
  logic             bank_we;
  logic [7:0]       out_byte;
  logic             rd_phase;

  ahb_bm_gap_timer #(
    .CNT_W (10),
    .LIMIT (int'(IDLE_GAP))
  ) u_gap (
    .clk   (hclk),
    .rst_n (hresetn),
    .run   (wait_run),
    .done  (wait_done)
  );

  ahb_bm_sequencer #(
    .ENABLE      (ENABLE),
    .BEATS       (BEATS),
    .TOTAL_BYTES (TOTAL_BYTES),
    .CNT_W       (CNT_W),
    .IDX_W       (IDX_W)
  ) u_seq (
    .clk       (hclk),
    .rst_n     (hresetn),
    .hready    (hready),
    .wait_done (wait_done),
    .phase     (phase),
    .addr_cnt  (addr_cnt),
    .issuing   (issuing),
    .wait_run  (wait_run),
    .dph_valid (dph_valid),
    .dph_rd    (dph_rd),
    .dph_idx   (dph_idx)
  );

  // A beat goes into the bank only if it completes with an OKAY response.
  assign bank_we = dph_valid && dph_rd && hready && resp_is_okay(hresp);

  ahb_bm_bank #(
    .ENTRIES (BEATS),
    .DATA_W  (DATA_W),
    .ENT_W   (ENT_W),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk         (hclk),
    .rst_n       (hresetn),
    .wr_en       (bank_we),
    .wr_idx      (dph_idx[ENT_W-1:0]),
    .wr_data     (hrdata),
    .rd_byte_idx (dph_idx),
    .rd_byte     (out_byte)
  );

  ahb_bm_lane_steer #(
    .DATA_W (DATA_W),
    .LANE   (DST_LANE)
  ) u_steer (
    .en       (dph_valid && !dph_rd),
    .byte_in  (out_byte),
    .data_out (hwdata)
  );

  assign rd_phase = (phase == PH_READ);

  always_comb begin
    if (!issuing)                    htrans = TRANS_IDLE;
    else if (rd_phase && addr_cnt != '0) htrans = TRANS_SEQ;
    else                             htrans = TRANS_NONSEQ;
  end

  assign haddr     = rd_phase ? (SRC_ADDR + (32'(addr_cnt) << LANE_W)) : DST_ADDR;
  assign hwrite    = (phase == PH_WRITE);
  assign hmastlock = (phase == PH_WRITE);
  assign hsize     = rd_phase ? SIZE_BEAT : SIZE_BYTE;
  assign hburst    = rd_phase ? BURST_INCR4 : BURST_SINGLE;

endmodule

// File: rtl/ahb_bm_checker.sv
module ahb_bm_checker
  import ahb_bm_pkg::*;
#(
  parameter bit          ENABLE   = 1'b1,
  parameter logic [31:0] SRC_ADDR = 32'h2000_0000,
  parameter logic [31:0] DST_ADDR = 32'h4000_0000,
  parameter int          DATA_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [2:0]        hburst,
  input logic              hmastlock,
  input logic [DATA_W-1:0] hwdata,
  input logic              hready
);

  localparam int          BEAT_BYTES = DATA_W / 8;
  localparam int          LANE       = int'(DST_ADDR[$clog2(BEAT_BYTES)-1:0]);
  localparam logic [DATA_W-1:0] KEEP = {{(DATA_W-8){1'b0}}, 8'hFF} << (8*LANE);

  assert_write_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hwrite) |-> hmastlock);

  assert_read_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && !hwrite) |-> !hmastlock);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)
                                && $stable(hsize) && $stable(hburst)));

  assert_write_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hwrite) |-> (htrans == TRANS_NONSEQ && haddr == DST_ADDR
                               && hsize == 3'b000 && hburst == BURST_SINGLE));

  assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TRANS_NONSEQ && !hwrite) |-> (haddr == SRC_ADDR && hburst == BURST_INCR4));

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TRANS_SEQ && $past(hready) && $past(htrans[1]))
      |-> (haddr == $past(haddr) + 32'(BEAT_BYTES)));

  assert_lane_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hwdata & ~KEEP) == '0);

  if (!ENABLE) begin : g_off
    assert_never_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
      htrans == TRANS_IDLE);
  end

endmodule

bind ahb_burst_byte_master ahb_bm_checker #(
  .ENABLE   (ENABLE),
  .SRC_ADDR (SRC_ADDR),
  .DST_ADDR (DST_ADDR),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (hclk),
  .rst_n     (hresetn),
  .haddr     (haddr),
  .htrans    (htrans),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .hburst    (hburst),
  .hmastlock (hmastlock),
  .hwdata    (hwdata),
  .hready    (hready)
);

// File: tb/ahb_burst_byte_master_bench.sv
module ahb_burst_byte_master_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          GAP        = 5;
  localparam logic [31:0] SRC        = 32'h2000_0000;
  localparam logic [31:0] DST        = 32'h4000_0005;
  localparam int          LANE       = 5;

  logic        clk = 1'b0;
  logic        hresetn;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic        hmastlock;
  logic [63:0] hwdata;
  logic [63:0] hrdata;
  logic        hready;
  logic [1:0]  hresp;

  logic [31:0] off_haddr;
  logic [1:0]  off_htrans;
  logic        off_hwrite;
  logic [2:0]  off_hsize;
  logic [2:0]  off_hburst;
  logic        off_hmastlock;
  logic [63:0] off_hwdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_burst_byte_master #(
    .SRC_TOP (8'h20), .SRC_LOW (24'h000000),
    .DST_TOP (8'h40), .DST_LOW (24'h000005),
    .IDLE_GAP (10'(GAP))
  ) u_ahb_burst_byte_master (
    .hclk (clk), .hresetn (hresetn), .haddr (haddr), .htrans (htrans),
    .hwrite (hwrite), .hsize (hsize), .hburst (hburst), .hmastlock (hmastlock),
    .hwdata (hwdata), .hrdata (hrdata), .hready (hready), .hresp (hresp)
  );

  ahb_burst_byte_master #(
    .ENABLE (1'b0), .IDLE_GAP (10'd2)
  ) u_off (
    .hclk (clk), .hresetn (hresetn), .haddr (off_haddr), .htrans (off_htrans),
    .hwrite (off_hwrite), .hsize (off_hsize), .hburst (off_hburst),
    .hmastlock (off_hmastlock), .hwdata (off_hwdata), .hrdata (64'h0),
    .hready (1'b1), .hresp (2'b00)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  expq[$];
  logic [63:0] model [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_data(input int r, input int b);
    logic [63:0] d;
    for (int j = 0; j < 8; j++) d[8*j +: 8] = 8'(r*64 + b*8 + j + 1);
    return d;
  endfunction

  // Driver side of the scoreboard: expected bytes for the next write phase.
  task automatic push_expected();
    for (int i = 0; i < 32; i++) expq.push_back(model[i/8][8*(i%8) +: 8]);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    bit          dp_valid = 0, dp_write = 0, err_pending = 0;
    int          dp_beat = 0, round = 0, rd_issued = 0, wr_done = 0;
    int          gap = 0, stall_tick = 0, off_bad = 0;
    bit          gap_checked = 0, hold_armed = 0, complete, err_now;
    logic [31:0] h_addr;
    logic [1:0]  h_trans;
    logic [6:0]  h_ctrl;
    logic [7:0]  got;

    for (int i = 0; i < 4; i++) model[i] = '0;
    hresetn = 1'b0; hready = 1'b1; hresp = 2'b00; hrdata = '0;
    repeat (3) @(negedge clk);
    check(htrans == 2'b00, "R1", "htrans in reset", 64'(htrans), 64'h0);
    check(hmastlock == 1'b0, "R1", "lock in reset", 64'(hmastlock), 64'h0);
    check(hwdata == '0, "R1", "hwdata in reset", hwdata, 64'h0);
    hresetn = 1'b1;

    for (int cyc = 0; cyc < 3000 && round < 3; cyc++) begin
      if (off_htrans != 2'b00) off_bad++;

      if (hold_armed) begin
        check(haddr == h_addr && htrans == h_trans && {hwrite, hsize, hburst} == h_ctrl,
              "R8", "address phase held under stall", {haddr, 30'h0, htrans}, {h_addr, 30'h0, h_trans});
        hold_armed = 0;
      end

      if (htrans == 2'b00 && !dp_valid) gap++;
      if (htrans == 2'b10 && !gap_checked) begin
        check(gap == GAP, "R2", "idle cycles before phase", 64'(gap), 64'(GAP));
        gap_checked = 1;
      end

      // Slave response for the current cycle.
      complete = 0; err_now = 0;
      hresp = 2'b00; hready = 1'b1;
      if (dp_valid) begin
        if (!dp_write) hrdata = beat_data(round, dp_beat);
        if (err_pending) begin
          hresp = 2'b01; err_pending = 0; complete = 1; err_now = 1;
        end else if (!dp_write && round == 1 && dp_beat == 2) begin
          hresp = 2'b01; hready = 1'b0; err_pending = 1;
        end else begin
          stall_tick++;
          if (round >= 1 && stall_tick % 3 == 1) hready = 1'b0;
          else complete = 1;
        end
      end

      if (complete) begin
        if (!dp_write) begin
          if (!err_now) model[dp_beat] = hrdata;  // R9 discard on error
          if (dp_beat == 3) begin
            push_expected();
            gap = 0; gap_checked = 0;
          end
        end else begin
          got = hwdata[8*LANE +: 8];
          if (expq.size() == 0) begin
            check(0, "R6", "unexpected write byte", 64'(got), 64'h0);
          end else begin
            check(got == expq[0], "R6", $sformatf("write byte %0d", wr_done), 64'(got), 64'(expq[0]));
            void'(expq.pop_front());
          end
          check((hwdata & ~(64'hFF << (8*LANE))) == '0, "R7", "other lanes zero", hwdata, 64'(got) << (8*LANE));
          wr_done++;
          if (wr_done == 32) begin
            wr_done = 0; round++; gap = 0; gap_checked = 0;
          end
        end
      end

      // Address phase acceptance.
      if (hready && htrans != 2'b00) begin
        if (!hwrite) begin
          check(haddr == SRC + 32'(rd_issued*8), (round > 0) ? "R10" : "R3",
                "read address", 64'(haddr), 64'(SRC + 32'(rd_issued*8)));
          check(htrans == ((rd_issued == 0) ? 2'b10 : 2'b11) && hburst == 3'b011 && hsize == 3'b011,
                "R3", "read control", {59'h0, htrans, hburst}, 64'h0);
          check(!hmastlock, "R5", "read unlocked", 64'(hmastlock), 64'h0);
          dp_beat = rd_issued; dp_write = 0;
          rd_issued = (rd_issued + 1) % 4;
        end else begin
          check(haddr == DST && htrans == 2'b10 && hburst == 3'b000 && hsize == 3'b000,
                (round > 0) ? "R10" : "R4", "write address/control", 64'(haddr), 64'(DST));
          check(hmastlock, "R5", "write locked", 64'(hmastlock), 64'h1);
          dp_write = 1;
        end
        dp_valid = 1;
      end else if (hready) begin
        dp_valid = 0;
      end else if (htrans != 2'b00) begin
        hold_armed = 1; h_addr = haddr; h_trans = htrans; h_ctrl = {hwrite, hsize, hburst};
      end

      @(negedge clk);
    end

    check(round == 3, "R10", "completed passes", 64'(round), 64'h3);
    check(expq.size() == 0, "R6", "scoreboard drained", 64'(expq.size()), 64'h0);
    check(off_bad == 0, "R11", "disabled instance active cycles", 64'(off_bad), 64'h0);
    finish_run();
  end

endmodule